// File: doc/BRIEF.md
# Deferred Prefetch-Fault Pipeline with Exception Entry

This block is the front end of a three-stage instruction pipeline: fetch, decode and execute. Each slot carries a valid bit, the fetch address, a fetch-fault tag and, once decode has classified it, a two-bit instruction class. A fetch that the memory side reports as failed is not acted on at once. The instruction is tagged as faulted and keeps moving down the pipeline like any other. The fault becomes an exception only when that instruction is the one in the execute slot. A redirect from the core discards the younger slots, and with them any fault tag they carry. A faulted fetch on a path that is later abandoned therefore costs nothing.

In the execute slot, the block picks the winning exception from a fetch fault, an undefined-instruction trap and a supervisor call. It then issues a one-cycle entry strobe with the target mode code, the vector address, the return link value and the new status word. It also copies the current status word into the saved-status register of the target mode. Taking an exception drains the two younger slots in the same way a redirect does.

Top module: `ftag_pipeline`

## Requirements
- R1: After reset, `exc_strobe` is 0, `exc_mode`, `exc_vector`, `exc_link` and `exc_status` are 0, all three saved-status outputs are 0, and the pipeline holds no instruction.
- R2: A fetch presented with `fetch_abort`=1 raises no exception while it is in fetch or decode. With `fetch_valid` high in the cycle before edge k, the entry strobe rises after edge k+3 and not earlier.
- R3: When `flush` is high in the cycle the instruction is on the fetch bus, in the fetch slot or in the decode slot, that instruction produces no strobe and leaves all saved-status outputs unchanged. This holds whatever its fault tag or class.
- R4: `flush` in the cycle the instruction occupies the execute slot does not cancel its exception.
- R5: `dec_class` is sampled in the cycle the instruction sits in decode. The encoding is 2'b00 plain, 2'b01 undefined, 2'b10 supervisor call and 2'b11 undefined. A fetch fault has priority over undefined, and undefined has priority over supervisor call.
- R6: The mode codes are 5'b10111 for a fetch fault, 5'b11011 for undefined and 5'b10011 for a supervisor call. The vectors are VEC_BASE plus 0x0C, 0x04 and 0x08 respectively.
- R7: `exc_link` equals the instruction address plus 4 for every kind. A fault handler returns with link minus 4. The trap and call handlers return to link unchanged.
- R8: `exc_status` equals `cur_status` with bits [4:0] replaced by the mode code and bit 7 (interrupt mask) set. All other bits are unchanged.
- R9: On entry, `cur_status` is written to the saved-status output of the target mode only: `spsr_abt`, `spsr_und` or `spsr_svc`.
- R10: Taking an exception discards the instructions in fetch and decode, so a second faulted instruction directly behind the first raises no strobe. The strobe lasts exactly one cycle.
- R11: A plain instruction with no fetch fault produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch bus holds an instruction this cycle |
| fetch_addr | input | AW | Address of the fetched instruction |
| fetch_abort | input | 1 | Memory reported a failed fetch |
| dec_class | input | 2 | Class of the instruction in decode |
| flush | input | 1 | Redirect: discard fetch and decode slots |
| cur_status | input | 32 | Current status word |
| exc_strobe | output | 1 | One-cycle exception entry pulse |
| exc_mode | output | 5 | Target mode code |
| exc_vector | output | AW | Handler vector address |
| exc_link | output | AW | Return link value |
| exc_status | output | 32 | Status word for the new mode |
| spsr_abt | output | 32 | Saved status, fetch-fault mode |
| spsr_und | output | 32 | Saved status, undefined mode |
| spsr_svc | output | 32 | Saved status, supervisor mode |

## Verification
The hardest situation to reach is a fault tag that is discarded at each separate pipeline position. A redirect must land in exactly the cycle the tagged instruction is on the bus, in fetch, in decode, or already in execute, where it must not cancel. The stimulus sweeps every combination of fault tag, class and redirect cycle around a single isolated instruction, so each position is hit on its own. A back-to-back pair of faulted fetches shows that the exception's own drain removes the second tag.

// File: rtl/ftag_pkg.sv
package ftag_pkg;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_PABT = 2'd1,
    EXC_UND  = 2'd2,
    EXC_SWI  = 2'd3
  } exc_kind_e;

  localparam int STATUS_W     = 32;
  localparam int MODE_W       = 5;
  localparam int IRQ_MASK_BIT = 7;
  localparam int NBANK        = 3;

  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;

  // class bits from decode: [0] undefined, [1] supervisor call
  function automatic exc_kind_e pick_kind(logic valid, logic fault, logic [1:0] cls);
    if (!valid)      return EXC_NONE;
    if (fault)       return EXC_PABT;
    if (cls[0])      return EXC_UND;
    if (cls == 2'b10) return EXC_SWI;
    return EXC_NONE;
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(exc_kind_e k);
    case (k)
      EXC_PABT: return MODE_ABT;
      EXC_UND:  return MODE_UND;
      EXC_SWI:  return MODE_SVC;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [7:0] vec_offset(exc_kind_e k);
    case (k)
      EXC_PABT: return 8'h0C;
      EXC_UND:  return 8'h04;
      EXC_SWI:  return 8'h08;
      default:  return 8'h00;
    endcase
  endfunction

  // bank slot: 0 fault mode, 1 undefined mode, 2 supervisor mode
  function automatic logic [NBANK-1:0] bank_sel(exc_kind_e k);
    case (k)
      EXC_PABT: return 3'b001;
      EXC_UND:  return 3'b010;
      EXC_SWI:  return 3'b100;
      default:  return 3'b000;
    endcase
  endfunction

  function automatic logic [STATUS_W-1:0] status_on_entry(logic [STATUS_W-1:0] cur,
                                                         exc_kind_e k);
    logic [STATUS_W-1:0] s;
    s = cur;
    s[MODE_W-1:0]   = mode_of(k);
    s[IRQ_MASK_BIT] = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/ftag_stage.sv
module ftag_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          in_valid,
  input  logic          in_fault,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_cls,
  output logic          q_valid,
  output logic          q_fault,
  output logic [AW-1:0] q_addr,
  output logic [1:0]    q_cls
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_fault <= 1'b0;
      q_addr  <= '0;
      q_cls   <= '0;
    end else begin
      q_valid <= in_valid & ~kill;
      q_fault <= in_valid & in_fault & ~kill;
      q_addr  <= in_addr;
      q_cls   <= in_cls;
    end
  end

  AST_KILL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !q_valid && !q_fault);  // R3

  AST_TAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    q_fault |-> q_valid);  // R2

endmodule

// File: rtl/ftag_arbiter.sv
module ftag_arbiter
  import ftag_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            INSN_BYTES = 4,
  parameter logic [AW-1:0] VEC_BASE   = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                e_valid,
  input  logic                e_fault,
  input  logic [1:0]          e_cls,
  input  logic [AW-1:0]       e_addr,
  input  logic [STATUS_W-1:0] cur_status,
  output exc_kind_e           kind,
  output logic                take,
  output logic [MODE_W-1:0]   mode,
  output logic [AW-1:0]       vector,
  output logic [AW-1:0]       link,
  output logic [STATUS_W-1:0] new_status
);

  always_comb begin
    kind       = pick_kind(e_valid, e_fault, e_cls);
    take       = (kind != EXC_NONE);
    mode       = mode_of(kind);
    vector     = VEC_BASE + AW'(vec_offset(kind));
    link       = e_addr + AW'(INSN_BYTES);
    new_status = status_on_entry(cur_status, kind);
  end

  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    e_valid && e_fault |-> kind == EXC_PABT);  // R5

  AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !e_valid |-> !take);  // R11

endmodule

// File: rtl/ftag_spsr_bank.sv
module ftag_spsr_bank #(
  parameter int NB = 3,
  parameter int W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0]        wr_sel,
  input  logic [W-1:0]         wr_data,
  output logic [NB-1:0][W-1:0] bank_q
);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)         bank_q[i] <= '0;
      else if (wr_sel[i]) bank_q[i] <= wr_data;
    end

    AST_BANK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel[i] |=> $stable(bank_q[i]));  // R9
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));  // R9

endmodule

// File: rtl/ftag_pipeline.sv
module ftag_pipeline
  import ftag_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            INSN_BYTES = 4,
  parameter logic [AW-1:0] VEC_BASE   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          fetch_abort,
  input  logic [1:0]    dec_class,
  input  logic          flush,
  input  logic [31:0]   cur_status,
  output logic          exc_strobe,
  output logic [4:0]    exc_mode,
  output logic [AW-1:0] exc_vector,
  output logic [AW-1:0] exc_link,
  output logic [31:0]   exc_status,
  output logic [31:0]   spsr_abt,
  output logic [31:0]   spsr_und,
  output logic [31:0]   spsr_svc
);

  localparam int NSTAGE = 3;
  localparam int S_FE   = 0;
  localparam int S_DE   = 1;
  localparam int S_EX   = 2;

  logic [NSTAGE-1:0] s_valid;
  logic [NSTAGE-1:0] s_fault;
  logic [AW-1:0]     s_addr [NSTAGE];
  logic [1:0]        s_cls  [NSTAGE];

  // named internal events
  logic                ex_take;
  logic                drain;
  exc_kind_e           ex_kind;
  logic [MODE_W-1:0]   ex_mode;
  logic [AW-1:0]       ex_vector;
  logic [AW-1:0]       ex_link;
  logic [STATUS_W-1:0] ex_status;
  logic [NBANK-1:0]    bank_wr;
  logic [NBANK-1:0][STATUS_W-1:0] bank_q;

  assign drain = flush | ex_take;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    logic          in_v;
    logic          in_f;
    logic [AW-1:0] in_a;
    logic [1:0]    in_c;
    if (i == 0) begin : g_head
      assign in_v = fetch_valid;
      assign in_f = fetch_abort;
      assign in_a = fetch_addr;
      assign in_c = 2'b00;
    end else if (i == S_EX) begin : g_exec
      assign in_v = s_valid[i-1];
      assign in_f = s_fault[i-1];
      assign in_a = s_addr[i-1];
      assign in_c = dec_class;
    end else begin : g_mid
      assign in_v = s_valid[i-1];
      assign in_f = s_fault[i-1];
      assign in_a = s_addr[i-1];
      assign in_c = s_cls[i-1];
    end
    ftag_stage #(.AW(AW)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .kill    (drain),
      .in_valid(in_v),
      .in_fault(in_f),
      .in_addr (in_a),
      .in_cls  (in_c),
      .q_valid (s_valid[i]),
      .q_fault (s_fault[i]),
      .q_addr  (s_addr[i]),
      .q_cls   (s_cls[i])
    );
  end

  ftag_arbiter #(.AW(AW), .INSN_BYTES(INSN_BYTES), .VEC_BASE(VEC_BASE)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .e_valid   (s_valid[S_EX]),
    .e_fault   (s_fault[S_EX]),
    .e_cls     (s_cls[S_EX]),
    .e_addr    (s_addr[S_EX]),
    .cur_status(cur_status),
    .kind      (ex_kind),
    .take      (ex_take),
    .mode      (ex_mode),
    .vector    (ex_vector),
    .link      (ex_link),
    .new_status(ex_status)
  );

  assign bank_wr = bank_sel(ex_kind);

  ftag_spsr_bank #(.NB(NBANK), .W(STATUS_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_sel (bank_wr),
    .wr_data(cur_status),
    .bank_q (bank_q)
  );

  assign spsr_abt = bank_q[0];
  assign spsr_und = bank_q[1];
  assign spsr_svc = bank_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_strobe <= 1'b0;
      exc_mode   <= '0;
      exc_vector <= '0;
      exc_link   <= '0;
      exc_status <= '0;
    end else begin
      exc_strobe <= ex_take;
      if (ex_take) begin
        exc_mode   <= ex_mode;
        exc_vector <= ex_vector;
        exc_link   <= ex_link;
        exc_status <= ex_status;
      end
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |=> !exc_strobe);  // R10

  AST_FROM_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_strobe) |-> $past(s_valid[S_EX]));  // R2

  AST_LINK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_strobe) |-> exc_link == $past(s_addr[S_EX]) + AW'(INSN_BYTES));  // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_strobe |-> exc_status[IRQ_MASK_BIT] && exc_status[MODE_W-1:0] == exc_mode);  // R8

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    drain |=> !s_valid[S_FE] && !s_valid[S_DE]);  // R10

  AST_SAVED_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exc_strobe) && exc_mode == MODE_SVC |-> spsr_svc == $past(cur_status));  // R9

endmodule

// File: tb/ftag_pipeline_bench.sv
`timescale 1ns/1ps
module ftag_pipeline_bench;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic          fetch_abort;
  logic [1:0]    dec_class;
  logic          flush;
  logic [31:0]   cur_status;
  logic          exc_strobe;
  logic [4:0]    exc_mode;
  logic [AW-1:0] exc_vector;
  logic [AW-1:0] exc_link;
  logic [31:0]   exc_status;
  logic [31:0]   spsr_abt, spsr_und, spsr_svc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] exp_bank [3];

  always #2.5 clk = ~clk;

  ftag_pipeline u_ftag_pipeline (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_abort(fetch_abort),
    .dec_class(dec_class), .flush(flush), .cur_status(cur_status),
    .exc_strobe(exc_strobe), .exc_mode(exc_mode), .exc_vector(exc_vector),
    .exc_link(exc_link), .exc_status(exc_status),
    .spsr_abt(spsr_abt), .spsr_und(spsr_und), .spsr_svc(spsr_svc)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // 1 fault, 2 undefined, 3 call, 0 none
  function automatic int want_kind(bit ab, logic [1:0] cls);
    if (ab) return 1;
    if (cls == 2'b01 || cls == 2'b11) return 2;
    if (cls == 2'b10) return 3;
    return 0;
  endfunction

  task automatic check_banks(input string tag);
    chk(spsr_abt == exp_bank[0], tag, spsr_abt, exp_bank[0]);
    chk(spsr_und == exp_bank[1], tag, spsr_und, exp_bank[1]);
    chk(spsr_svc == exp_bank[2], tag, spsr_svc, exp_bank[2]);
  endtask

  task automatic idle();
    fetch_valid = 1'b0; fetch_abort = 1'b0; dec_class = 2'b00; flush = 1'b0;
  endtask

  task automatic run_one(input logic [31:0] addr, input bit ab, input logic [1:0] cls,
                         input int flush_at, input logic [31:0] st);
    int n = 0;
    int seen = -1;
    logic [4:0]  m = '0;
    logic [31:0] v = '0, l = '0, s = '0;
    int k;
    bit expect_exc;
    logic [4:0] em;
    logic [31:0] ev, es;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (exc_strobe) begin
        n++; seen = c; m = exc_mode; v = exc_vector; l = exc_link; s = exc_status;
      end
      fetch_valid = (c == 0);
      fetch_addr  = addr;
      fetch_abort = ab && (c == 0);
      dec_class   = (c == 2) ? cls : 2'b00;
      flush       = (c == flush_at);
      cur_status  = st;
    end
    k = want_kind(ab, cls);
    expect_exc = (k != 0) && !(flush_at >= 0 && flush_at <= 2);
    if (!expect_exc) begin
      chk(n == 0, (k == 0) ? "R11 plain no strobe" : "R3 cancelled no strobe", n, 0);
      check_banks("R3 banks unchanged");
    end else begin
      em = (k == 1) ? 5'b10111 : (k == 2) ? 5'b11011 : 5'b10011;
      ev = 32'h0000_0004 * ((k == 1) ? 3 : (k == 2) ? 1 : 2);
      es = (st & ~32'h0000_009F) | {27'd0, em} | 32'h0000_0080;
      exp_bank[k-1] = st;
      chk(n == 1, "R10 single strobe", n, 1);
      chk(seen == 4, (flush_at == 3) ? "R4 exec flush keeps, timing" : "R2 deferred timing", seen, 4);
      chk(m == em, "R5/R6 mode", {27'd0, m}, {27'd0, em});
      chk(v == ev, "R6 vector", v, ev);
      chk(l == addr + 32'd4, "R7 link", l, addr + 32'd4);
      chk(s == es, "R8 status", s, es);
      check_banks("R9 saved status");
    end
  endtask

  initial begin
    int run = 0;
    rst_n = 1'b0; fetch_addr = '0; cur_status = '0;
    idle();
    for (int i = 0; i < 3; i++) exp_bank[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(exc_strobe == 1'b0, "R1 strobe", exc_strobe, 0);
    chk(exc_mode == 5'd0, "R1 mode", exc_mode, 0);
    chk(exc_link == '0 && exc_vector == '0, "R1 link/vector", exc_link, 0);
    chk(exc_status == '0, "R1 status", exc_status, 0);
    check_banks("R1 banks");

    for (int ab = 0; ab < 2; ab++) begin
      for (int cls = 0; cls < 4; cls++) begin
        for (int fa = -1; fa < 4; fa++) begin
          logic [31:0] a = 32'h0000_1000 + 32'(run) * 32'h40;
          logic [31:0] st = 32'hA5C3_0010 ^ (32'(run) * 32'h0101_0101);
          run_one(a, ab[0], cls[1:0], fa, st);
          run++;
        end
      end
    end

    // R10 back-to-back faulted fetches: only the first is taken
    begin
      int n = 0;
      logic [31:0] l = '0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (exc_strobe) begin n++; l = exc_link; end
        fetch_valid = (c < 3);
        fetch_addr  = 32'h0000_8000 + 32'(c) * 32'd4;
        fetch_abort = (c < 3);
        dec_class   = 2'b10;
        flush       = 1'b0;
        cur_status  = 32'h1234_5613;
      end
      idle();
      chk(n == 1, "R10 drain second fault", n, 1);
      chk(l == 32'h0000_8004, "R10 first wins link", l, 32'h0000_8004);
      chk(spsr_abt == 32'h1234_5613, "R9 back-to-back bank", spsr_abt, 32'h1234_5613);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule